// File: doc/BRIEF.md
# Status and Write-Protect Controller

This block keeps the eight-bit status byte of a serial non-volatile memory and decides, one command at a time, whether a status write or an array write may start. A command engine upstream decodes the serial stream and hands over single-cycle strobes: set the write-enable latch, clear it, write the status byte (with its data byte), or write the array (with the target address). The controller answers each write strobe with a one-cycle grant or reject pulse. It also tracks the self-timed programming cycle until a done pulse arrives from the array timer.

Protection has two layers. Two block-protect bits mark a region at the top of the array as read-only, and `addr_prot_o` reports whether the page holding the current address falls inside it. A status-write-disable bit, combined with an active-low write-protect pin, freezes the status byte itself. New protection values written by a status write are held aside and only replace the live values when the self-timed cycle ends, so every check made while the cycle runs still uses the old values. The non-volatile bits are modelled as flops whose reset value is zero.

Top module: `wprot_status_ctrl`

## Requirements
- R1: `status_o` packs, from bit 7 to bit 0: status-write-disable, three constant zeros, block-protect high, block-protect low, write-enable latch, write-in-progress. Bits 6..4 always read 0, and after reset the whole byte is 8'h00.
- R2: A `cmd_wren_i` strobe sets the write-enable latch (bit 1) and a `cmd_wrdi_i` strobe clears it. The change is visible on `status_o` after the capturing clock edge.
- R3: A status write is granted only when the latch is 1, write-in-progress is 0 and the byte is not hardware-locked. `sr_grant_o` or `sr_reject_o` pulses for one cycle after the edge that captures the strobe, and write-in-progress reads 1 from that same edge when the write is granted.
- R4: The status byte is hardware-locked while status-write-disable is 1 and `wp_n_i` is 0. This holds whichever of the two conditions came first, and a locked status write is rejected and leaves the latch set. Driving `wp_n_i` high lifts the lock.
- R5: A granted status write takes only data bits 7, 3 and 2 and ignores bits 6..4, 1 and 0. The captured values replace status-write-disable and block-protect only at the end of the cycle. Until then `status_o` and `addr_prot_o` keep the old values.
- R6: `cycle_done_i` during a running cycle clears write-in-progress and the write-enable latch on the next edge. `cycle_done_i` while no cycle runs changes nothing.
- R7: An array write is granted only when the latch is 1, write-in-progress is 0 and `addr_prot_o` is 0. Otherwise it is rejected and the latch keeps its value.
- R8: With an 11-bit address, `addr_prot_o` is driven combinationally from the page that holds `addr_i`. Block-protect 00 protects nothing, 01 protects pages at or above 0x600, 10 protects pages at or above 0x400, and 11 protects every address.
- R9: A status or array write that arrives while a cycle runs is rejected, including one that arrives in the same cycle as `cycle_done_i`.
- R10: A `cmd_wren_i` strobe in the same cycle as the `cycle_done_i` that ends a cycle leaves the write-enable latch at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset (power-up) |
| cmd_wren_i | input | 1 | Strobe: set write-enable latch |
| cmd_wrdi_i | input | 1 | Strobe: clear write-enable latch |
| cmd_sr_write_i | input | 1 | Strobe: status write request |
| sr_data_i | input | 8 | Data byte of the status write |
| cmd_arr_write_i | input | 1 | Strobe: array write request |
| addr_i | input | ADDR_W | Start address of the array write |
| wp_n_i | input | 1 | Write-protect pin, active low |
| cycle_done_i | input | 1 | End of the self-timed programming cycle |
| status_o | output | 8 | Status byte for readback |
| sr_grant_o | output | 1 | Status write accepted (one-cycle pulse) |
| sr_reject_o | output | 1 | Status write refused (one-cycle pulse) |
| arr_grant_o | output | 1 | Array write accepted (one-cycle pulse) |
| arr_reject_o | output | 1 | Array write refused (one-cycle pulse) |
| addr_prot_o | output | 1 | Page of `addr_i` lies in the protected region |

## Verification
The properties assume that the command engine raises at most one of the four command strobes in any cycle and holds each for exactly one cycle. They also assume that `sr_data_i` and `addr_i` are valid whenever their strobe is high. The bench drives every command through tasks that raise one strobe for one cycle, and its random phase picks a single command per cycle. `cycle_done_i` and `wp_n_i` are left free, so done pulses land on idle cycles, on busy cycles and next to enable strobes. The pin also changes at arbitrary points between a status-write-disable update and later status writes.

// File: rtl/wps_pkg.sv
package wps_pkg;

    localparam int STAT_W  = 8;
    localparam int POS_SWD = 7;
    localparam int POS_BPH = 3;
    localparam int POS_BPL = 2;
    localparam int POS_WEL = 1;
    localparam int POS_WIP = 0;

    typedef enum logic {
        OP_ARRAY  = 1'b0,
        OP_STATUS = 1'b1
    } wps_op_e;

    typedef struct packed {
        logic       swd;
        logic [1:0] bp;
        logic       wel;
        logic       wip;
        wps_op_e    op;
        logic       stg_swd;
        logic [1:0] stg_bp;
        logic       sr_grant;
        logic       sr_reject;
        logic       arr_grant;
        logic       arr_reject;
    } wps_state_t;

    function automatic logic [STAT_W-1:0] pack_status(input wps_state_t s);
        logic [STAT_W-1:0] b;
        b          = '0;
        b[POS_SWD] = s.swd;
        b[POS_BPH] = s.bp[1];
        b[POS_BPL] = s.bp[0];
        b[POS_WEL] = s.wel;
        b[POS_WIP] = s.wip;
        return b;
    endfunction

endpackage

// File: rtl/wps_region_check.sv
module wps_region_check #(
    parameter int ADDR_W = 11,
    parameter int PAGE_W = 5
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [1:0]        bp_i,
    output logic              prot_o
);
    localparam logic [ADDR_W-1:0] PAGE_MASK = ADDR_W'((1 << PAGE_W) - 1);
    localparam logic [ADDR_W-1:0] LIM_QTR   = {2'b11, {(ADDR_W-2){1'b0}}};
    localparam logic [ADDR_W-1:0] LIM_HALF  = {1'b1,  {(ADDR_W-1){1'b0}}};

    logic [ADDR_W-1:0] page_base;

    always_comb begin
        page_base = addr_i & ~PAGE_MASK;
        unique case (bp_i)
            2'b00:   prot_o = 1'b0;
            2'b01:   prot_o = (page_base >= LIM_QTR);
            2'b10:   prot_o = (page_base >= LIM_HALF);
            default: prot_o = 1'b1;
        endcase
    end
endmodule

// File: rtl/wps_grant_decide.sv
module wps_grant_decide (
    input  logic sr_req_i,
    input  logic arr_req_i,
    input  logic wel_i,
    input  logic wip_i,
    input  logic swd_i,
    input  logic wp_n_i,
    input  logic addr_prot_i,
    output logic sr_ok_o,
    output logic arr_ok_o
);
    logic hw_locked;
    logic armed;

    always_comb begin
        hw_locked = swd_i && !wp_n_i;
        armed     = wel_i && !wip_i;
        sr_ok_o   = sr_req_i && armed && !hw_locked;
        arr_ok_o  = arr_req_i && !sr_req_i && armed && !addr_prot_i;
    end
endmodule

// File: rtl/wprot_status_ctrl.sv
module wprot_status_ctrl
    import wps_pkg::*;
#(
    parameter int ADDR_W = 11,
    parameter int PAGE_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_wren_i,
    input  logic              cmd_wrdi_i,
    input  logic              cmd_sr_write_i,
    input  logic [7:0]        sr_data_i,
    input  logic              cmd_arr_write_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              wp_n_i,
    input  logic              cycle_done_i,
    output logic [7:0]        status_o,
    output logic              sr_grant_o,
    output logic              sr_reject_o,
    output logic              arr_grant_o,
    output logic              arr_reject_o,
    output logic              addr_prot_o
);
    localparam wps_state_t ST_RESET = '{
        swd: 1'b0, bp: 2'b00, wel: 1'b0, wip: 1'b0, op: OP_ARRAY,
        stg_swd: 1'b0, stg_bp: 2'b00,
        sr_grant: 1'b0, sr_reject: 1'b0, arr_grant: 1'b0, arr_reject: 1'b0
    };

    wps_state_t st_d, st_q;
    logic       prot_live;
    logic       sr_ok, arr_ok;
    logic       unused_sr_bits;

    assign unused_sr_bits = ^{sr_data_i[6:4], sr_data_i[1:0]};

    wps_region_check #(
        .ADDR_W (ADDR_W),
        .PAGE_W (PAGE_W)
    ) u_region (
        .addr_i (addr_i),
        .bp_i   (st_q.bp),
        .prot_o (prot_live)
    );

    wps_grant_decide u_grant (
        .sr_req_i    (cmd_sr_write_i),
        .arr_req_i   (cmd_arr_write_i),
        .wel_i       (st_q.wel),
        .wip_i       (st_q.wip),
        .swd_i       (st_q.swd),
        .wp_n_i      (wp_n_i),
        .addr_prot_i (prot_live),
        .sr_ok_o     (sr_ok),
        .arr_ok_o    (arr_ok)
    );

    always_comb begin
        st_d            = st_q;
        st_d.sr_grant   = sr_ok;
        st_d.sr_reject  = cmd_sr_write_i && !sr_ok;
        st_d.arr_grant  = arr_ok;
        st_d.arr_reject = cmd_arr_write_i && !arr_ok;

        // end of the self-timed cycle: commit staged protection values
        if (st_q.wip && cycle_done_i) begin
            st_d.wip = 1'b0;
            st_d.wel = 1'b0;
            if (st_q.op == OP_STATUS) begin
                st_d.swd = st_q.stg_swd;
                st_d.bp  = st_q.stg_bp;
            end
        end

        if (cmd_wren_i) st_d.wel = 1'b1;
        if (cmd_wrdi_i) st_d.wel = 1'b0;

        if (sr_ok) begin
            st_d.wip     = 1'b1;
            st_d.op      = OP_STATUS;
            st_d.stg_swd = sr_data_i[POS_SWD];
            st_d.stg_bp  = {sr_data_i[POS_BPH], sr_data_i[POS_BPL]};
        end else if (arr_ok) begin
            st_d.wip = 1'b1;
            st_d.op  = OP_ARRAY;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_RESET;
        else        st_q <= st_d;
    end

    assign status_o     = pack_status(st_q);
    assign sr_grant_o   = st_q.sr_grant;
    assign sr_reject_o  = st_q.sr_reject;
    assign arr_grant_o  = st_q.arr_grant;
    assign arr_reject_o = st_q.arr_reject;
    assign addr_prot_o  = prot_live;
endmodule

// File: rtl/wps_checker.sv
module wps_checker #(
    parameter int ADDR_W = 11
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cmd_wren_i,
    input logic              cmd_wrdi_i,
    input logic              cmd_sr_write_i,
    input logic              cmd_arr_write_i,
    input logic [ADDR_W-1:0] addr_i,
    input logic              wp_n_i,
    input logic              cycle_done_i,
    input logic [7:0]        status_o,
    input logic              sr_grant_o,
    input logic              sr_reject_o,
    input logic              arr_grant_o,
    input logic              arr_reject_o,
    input logic              addr_prot_o
);
    // input contract: one command strobe per cycle
    a_r3_single_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cmd_wren_i, cmd_wrdi_i, cmd_sr_write_i, cmd_arr_write_i}));

    a_r1_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        status_o[6:4] == 3'b000);

    a_r2_wren_sets: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_wren_i |=> status_o[1]);

    a_r3_no_latch_reject: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_sr_write_i && !status_o[1] |=> sr_reject_o && !sr_grant_o);

    a_r3_grant_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (sr_grant_o || arr_grant_o) |-> status_o[0]);

    a_r3_one_answer: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({sr_grant_o, sr_reject_o, arr_grant_o, arr_reject_o}));

    a_r4_hw_lock: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_sr_write_i && status_o[7] && !wp_n_i |=> sr_reject_o);

    a_r5_prot_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(status_o[0] && cycle_done_i) |=> $stable(status_o[7:2]));

    a_r6_done_clears: assert property (@(posedge clk) disable iff (!rst_n)
        status_o[0] && cycle_done_i && !cmd_wren_i |=> status_o[1:0] == 2'b00);

    a_r7_prot_reject: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_arr_write_i && addr_prot_o |=> arr_reject_o);

    a_r8_whole: assert property (@(posedge clk) disable iff (!rst_n)
        status_o[3:2] == 2'b11 |-> addr_prot_o);

    a_r8_none: assert property (@(posedge clk) disable iff (!rst_n)
        status_o[3:2] == 2'b00 |-> !addr_prot_o);

    a_r9_busy_reject: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_arr_write_i && status_o[0] |=> arr_reject_o);

    a_r10_wren_wins: assert property (@(posedge clk) disable iff (!rst_n)
        status_o[0] && cycle_done_i && cmd_wren_i |=> status_o[1]);
endmodule

bind wprot_status_ctrl wps_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .cmd_wren_i      (cmd_wren_i),
    .cmd_wrdi_i      (cmd_wrdi_i),
    .cmd_sr_write_i  (cmd_sr_write_i),
    .cmd_arr_write_i (cmd_arr_write_i),
    .addr_i          (addr_i),
    .wp_n_i          (wp_n_i),
    .cycle_done_i    (cycle_done_i),
    .status_o        (status_o),
    .sr_grant_o      (sr_grant_o),
    .sr_reject_o     (sr_reject_o),
    .arr_grant_o     (arr_grant_o),
    .arr_reject_o    (arr_reject_o),
    .addr_prot_o     (addr_prot_o)
);

// File: tb/sim_wprot_status_ctrl.sv
`timescale 1ns/1ps
module sim_wprot_status_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wren = 0, wrdi = 0, srw = 0, arw = 0, done = 0, wp_n = 1;
    logic [7:0]  sdat = '0;
    logic [10:0] addr = '0;
    logic [7:0]  status;
    logic        srg, srr, arg, arr, prot;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    wprot_status_ctrl u0 (
        .clk (clk), .rst_n (rst_n),
        .cmd_wren_i (wren), .cmd_wrdi_i (wrdi),
        .cmd_sr_write_i (srw), .sr_data_i (sdat),
        .cmd_arr_write_i (arw), .addr_i (addr),
        .wp_n_i (wp_n), .cycle_done_i (done),
        .status_o (status), .sr_grant_o (srg), .sr_reject_o (srr),
        .arr_grant_o (arg), .arr_reject_o (arr), .addr_prot_o (prot)
    );

    // behavioural reference
    bit       m_swd, m_wel, m_wip, m_is_sr, m_nswd;
    bit [1:0] m_bp, m_nbp;
    bit       e_srg, e_srr, e_arg, e_arr;

    function automatic bit m_prot(bit [1:0] bp, int a);
        case (bp)
            2'd0:    return 0;
            2'd1:    return a >= 1536;
            2'd2:    return a >= 1024;
            default: return 1;
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_swd = 0; m_bp = 0; m_wel = 0; m_wip = 0; m_is_sr = 0;
            m_nswd = 0; m_nbp = 0;
            e_srg = 0; e_srr = 0; e_arg = 0; e_arr = 0;
        end else begin
            bit ok_sr, ok_ar;
            ok_sr = srw && m_wel && !m_wip && !(m_swd && !wp_n);
            ok_ar = arw && m_wel && !m_wip && !m_prot(m_bp, int'(addr));
            e_srg = ok_sr; e_srr = srw && !ok_sr;
            e_arg = ok_ar; e_arr = arw && !ok_ar;
            if (m_wip && done) begin
                m_wip = 0; m_wel = 0;
                if (m_is_sr) begin m_swd = m_nswd; m_bp = m_nbp; end
            end
            if (wren) m_wel = 1;
            if (wrdi) m_wel = 0;
            if (ok_sr) begin
                m_wip = 1; m_is_sr = 1; m_nswd = sdat[7]; m_nbp = sdat[3:2];
            end else if (ok_ar) begin
                m_wip = 1; m_is_sr = 0;
            end
        end
    end

    task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h at %0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && !finished) begin
            chk("R1 reserved bits", {5'd0, status[6:4]}, 8'h00);
            chk("R2 latch", {7'd0, status[1]}, {7'd0, m_wel});
            chk("R6 busy flag", {7'd0, status[0]}, {7'd0, m_wip});
            chk("R5 protect bits", {status[7], status[3:2]}, {m_swd, m_bp});
            chk("R3 status answer", {srg, srr}, {e_srg, e_srr});
            chk("R7 array answer", {arg, arr}, {e_arg, e_arr});
            chk("R8 region flag", {7'd0, prot}, {7'd0, m_prot(m_bp, int'(addr))});
        end
    end

    task automatic tick();
        @(posedge clk); #2;
    endtask
    task automatic do_wren(); wren = 1; tick(); wren = 0; endtask
    task automatic do_wrdi(); wrdi = 1; tick(); wrdi = 0; endtask
    task automatic do_sr(input logic [7:0] d);
        sdat = d; srw = 1; tick(); srw = 0;
    endtask
    task automatic do_arr(input logic [10:0] a);
        addr = a; arw = 1; tick(); arw = 0;
    endtask
    task automatic do_done(); done = 1; tick(); done = 0; endtask
    task automatic probe(input logic [10:0] a, input bit exp, string tag);
        addr = a; #1; chk(tag, {7'd0, prot}, {7'd0, exp});
    endtask

    initial begin
        #400000;
        if (!finished) begin
            finished = 1;
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) tick();
        rst_n = 1;
        tick();
        chk("R1 reset value", status, 8'h00);

        do_sr(8'h8C);                 chk("R3 no latch", {srg, srr}, 2'b01);
        do_wren();                    chk("R2 set", status, 8'h02);
        do_wrdi();                    chk("R2 clear", status, 8'h00);

        do_wren();
        do_arr(11'h7FF);              chk("R7 grant", {arg, arr}, 2'b10);
                                      chk("R3 busy", status, 8'h03);
        do_arr(11'h010);              chk("R9 array busy", {arg, arr}, 2'b01);
        do_sr(8'h00);                 chk("R9 status busy", {srg, srr}, 2'b01);
        do_done();                    chk("R6 end", status, 8'h00);

        do_wren();
        do_sr(8'hFF);                 chk("R3 grant", {srg, srr}, 2'b10);
                                      chk("R5 old kept", status, 8'h03);
        probe(11'h7FF, 0, "R5 old region");
        do_done();                    chk("R5 commit", status, 8'h8C);

        wp_n = 0;
        do_wren();
        do_sr(8'h00);                 chk("R4 locked", {srg, srr}, 2'b01);
                                      chk("R4 latch kept", status, 8'h8E);
        wp_n = 1;
        do_sr(8'h00);                 chk("R4 unlocked", {srg, srr}, 2'b10);
        do_done();                    chk("R4 cleared", status, 8'h00);

        wp_n = 0;
        do_wren();
        do_sr(8'h80);                 chk("R4 pin first", {srg, srr}, 2'b10);
        do_done();                    chk("R4 swd set", status, 8'h80);
        do_wren();
        do_sr(8'h00);                 chk("R4 lock order", {srg, srr}, 2'b01);
        wp_n = 1;
        do_sr(8'h00);                 chk("R4 exit", {srg, srr}, 2'b10);
        do_done();

        do_wren(); do_sr(8'h04); do_done();
        chk("R8 quarter set", status, 8'h04);
        probe(11'h600, 1, "R8 quarter base");
        probe(11'h61F, 1, "R8 quarter page");
        probe(11'h5FF, 0, "R8 below quarter");
        do_wren();
        do_arr(11'h600);              chk("R7 protected", {arg, arr}, 2'b01);
                                      chk("R7 latch kept", status, 8'h06);
        do_arr(11'h100);              chk("R7 open grant", {arg, arr}, 2'b10);
        do_done();

        do_wren(); do_sr(8'h08); do_done();
        probe(11'h400, 1, "R8 half base");
        probe(11'h3FF, 0, "R8 below half");
        do_wren(); do_sr(8'h7F); do_done();
        chk("R5 ignored bits", status, 8'h0C);
        probe(11'h000, 1, "R8 whole");

        do_done();                    chk("R6 idle done", status, 8'h0C);
        do_wren(); do_sr(8'h00);
        wren = 1; done = 1; tick(); wren = 0; done = 0;
        chk("R10 enable wins", status, 8'h02);
        do_wrdi();

        for (int i = 0; i < 3000; i++) begin
            int c;
            c = $urandom_range(0, 9);
            sdat = 8'($urandom);
            addr = 11'($urandom);
            done = ($urandom_range(0, 3) == 0);
            if ($urandom_range(0, 15) == 0) wp_n = ~wp_n;
            wren = (c == 0 || c == 1);
            wrdi = (c == 2);
            srw  = (c == 3 || c == 4);
            arw  = (c == 5 || c == 6);
            tick();
        end
        {wren, wrdi, srw, arw, done} = '0;
        tick(); tick();

        if (!finished) begin
            finished = 1;
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end
endmodule